// File: doc/BRIEF.md
# Handshaked Running-Average Filter

This block is a single-channel filter stage that averages consecutive samples. It accepts one sample at a time on a four-phase request/acknowledge input channel. For each sample it produces the mean of that sample and the sample before it, then sends the result on a four-phase request/acknowledge output channel. The remembered sample starts at zero. It is replaced by the new sample only once the consumer has accepted the result.

Inside, a controller clocked by the system clock sequences four parts: a capture register for the incoming sample, a register for the previous sample, an adder followed by a divide-by-two shift, and an output register. The adder works like a bundled-data stage. The controller raises a request to it, and a completion signal comes back after a configurable number of cycles that stands in for the matched delay. The input acknowledge is raised only after the sample has been captured, so the producer may change its data as soon as it sees the acknowledge.

Top module: `avg_filter_hs`

## Requirements
- R1: After reset, in_ack and out_req are low, and the remembered previous sample is 0, so the first result equals the first sample divided by two.
- R2: Each result equals floor((x + y) / 2) for the current sample x and previous sample y. The sum is formed one bit wider than the data, so two full-scale samples give full scale.
- R3: The previous sample takes the value of the current sample only after the output handshake for its result has been acknowledged. The results therefore follow the pairwise averages of the input sequence in order.
- R4: in_ack rises only while in_req is high and after in_data has been captured. Changes to in_data after in_ack rises have no effect on the result.
- R5: in_ack stays high as long as in_req stays high, and falls only after in_req has fallen (return-to-zero on the input channel).
- R6: While out_req is high and out_ack is low, out_req stays high and out_data is stable. After out_ack rises, out_req falls, and it is not raised again while out_ack is still high.
- R7: At most one sample is in flight: in_ack is never high while out_req is high.
- R8: out_req rises exactly max(ADD_LAT,1) clock cycles after in_ack falls, where ADD_LAT is the adder completion latency in cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_req | input | 1 | Input request: in_data is valid |
| in_ack | output | 1 | Input acknowledge: sample captured |
| in_data | input | DATA_W | Input sample (unsigned) |
| out_req | output | 1 | Output request: out_data is valid |
| out_ack | input | 1 | Output acknowledge from the consumer |
| out_data | output | DATA_W | Average of current and previous sample |

## Verification
The bench builds the block with DATA_W = 8 and ADD_LAT = 3. With 8-bit data, full-scale pairs and odd sums come up often, so the widened sum and the rounding toward zero are exercised. A latency of 3 makes the completion counter step through several states, so an off-by-one in the adder delay shows up in the measured in_ack-to-out_req gap. Random handshake delays on both channels, together with corrupted input data after acknowledge, test that the state update waits for the output acknowledge and that the sample is held after capture.

// File: rtl/avg_pkg.sv
package avg_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_INACK = 3'd1,
      ST_ADD   = 3'd2,
      ST_OREQ  = 3'd3,
      ST_ORET  = 3'd4
   } hs_state_t;
endpackage

// File: rtl/avg_ctrl.sv
module avg_ctrl
   import avg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic in_req,
   input  logic out_ack,
   input  logic add_done,
   output logic in_ack,
   output logic out_req,
   output logic add_req,
   output logic load_x,
   output logic load_out,
   output logic load_y
);
   hs_state_t state_q, state_d;

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (in_req)   state_d = ST_INACK;
         ST_INACK: if (!in_req)  state_d = ST_ADD;
         ST_ADD:   if (add_done) state_d = ST_OREQ;
         ST_OREQ:  if (out_ack)  state_d = ST_ORET;
         ST_ORET:  if (!out_ack) state_d = ST_IDLE;
         default:                state_d = ST_IDLE;
      endcase
   end

   assign in_ack   = (state_q == ST_INACK);
   assign out_req  = (state_q == ST_OREQ);
   assign add_req  = (state_q == ST_ADD);
   assign load_x   = (state_q == ST_IDLE) && in_req;
   assign load_out = (state_q == ST_ADD)  && add_done;
   assign load_y   = (state_q == ST_OREQ) && out_ack;
endmodule

// File: rtl/avg_add_delay.sv
module avg_add_delay #(
   parameter int ADD_LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic done
);
   generate
      if (ADD_LAT == 0) begin : g_instant
         assign done = req;
      end else begin : g_counted
         localparam int CW = (ADD_LAT < 2) ? 1 : $clog2(ADD_LAT);
         localparam logic [CW-1:0] LAST = CW'(ADD_LAT - 1);
         logic [CW-1:0] cnt_q;
         assign done = req && (cnt_q == LAST);
         always_ff @(posedge clk) begin
            if (!rst_n || !req) cnt_q <= '0;
            else if (!done)     cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/avg_datapath.sv
module avg_datapath #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_x,
   input  logic              load_out,
   input  logic              load_y,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int SUM_W = DATA_W + 1;

   logic [DATA_W-1:0] x_q, y_q, out_q;
   logic [SUM_W-1:0]  sum;

   assign sum  = {1'b0, x_q} + {1'b0, y_q};
   assign dout = out_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q   <= '0;
         y_q   <= '0;
         out_q <= '0;
      end else begin
         if (load_x)   x_q   <= din;
         if (load_out) out_q <= sum[SUM_W-1:1];
         if (load_y)   y_q   <= x_q;
      end
   end
endmodule

// File: rtl/avg_filter_hs.sv
module avg_filter_hs #(
   parameter int DATA_W  = 8,
   parameter int ADD_LAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_req,
   output logic              in_ack,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_req,
   input  logic              out_ack,
   output logic [DATA_W-1:0] out_data
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("avg_filter_hs: DATA_W must be at least 1");
      end
      if (ADD_LAT < 0) begin : g_bad_lat
         $error("avg_filter_hs: ADD_LAT must not be negative");
      end
   endgenerate

   logic add_req, add_done, load_x, load_out, load_y;

   avg_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_req   (in_req),
      .out_ack  (out_ack),
      .add_done (add_done),
      .in_ack   (in_ack),
      .out_req  (out_req),
      .add_req  (add_req),
      .load_x   (load_x),
      .load_out (load_out),
      .load_y   (load_y)
   );

   avg_add_delay #(.ADD_LAT(ADD_LAT)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (add_req),
      .done  (add_done)
   );

   avg_datapath #(.DATA_W(DATA_W)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_x   (load_x),
      .load_out (load_out),
      .load_y   (load_y),
      .din      (in_data),
      .dout     (out_data)
   );
endmodule

// File: rtl/avg_filter_hs_chk.sv
module avg_filter_hs_chk #(
   parameter int DATA_W  = 8,
   parameter int ADD_LAT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_req,
   input logic              in_ack,
   input logic              out_req,
   input logic              out_ack,
   input logic [DATA_W-1:0] out_data
);
   localparam int CW = $clog2(ADD_LAT + 2) + 1;
   localparam logic [CW-1:0] CMAX = '1;

   logic [CW-1:0] gap_q;
   always_ff @(posedge clk) begin
      if (!rst_n || in_ack) gap_q <= '0;
      else if (gap_q != CMAX) gap_q <= gap_q + 1'b1;
   end

   p_reset_idle_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> !in_ack && !out_req);

   p_ack_after_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ack) |-> $past(in_req));

   p_ack_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_ack && in_req |=> in_ack);

   p_out_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_req && !out_ack |=> out_req && $stable(out_data));

   p_out_rtz_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_req && out_ack |=> !out_req);

   p_one_in_flight_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ack && out_req));

   p_add_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_req) |-> (32'(gap_q) >= ADD_LAT));
endmodule

bind avg_filter_hs avg_filter_hs_chk #(.DATA_W(DATA_W), .ADD_LAT(ADD_LAT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_req   (in_req),
   .in_ack   (in_ack),
   .out_req  (out_req),
   .out_ack  (out_ack),
   .out_data (out_data)
);

// File: tb/avg_filter_hs_test.sv
module avg_filter_hs_test;
   localparam int DW  = 8;
   localparam int LAT = 3;
   localparam int NRAND = 300;
   localparam int MAXN = 400;
   localparam int EXP_GAP = (LAT < 1) ? 1 : LAT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_req = 1'b0;
   logic in_ack;
   logic [DW-1:0] in_data = '0;
   logic out_req;
   logic out_ack = 1'b0;
   logic [DW-1:0] out_data;

   int checks = 0;
   int errors = 0;
   int n_sent = 0;
   int n_recv = 0;
   int y_model = 0;
   logic [DW-1:0] exp_q [MAXN];
   bit done_flag = 0;

   always #5 clk = ~clk;

   avg_filter_hs #(.DATA_W(DW), .ADD_LAT(LAT)) uut (
      .clk(clk), .rst_n(rst_n),
      .in_req(in_req), .in_ack(in_ack), .in_data(in_data),
      .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
   );

   function automatic logic [DW-1:0] avg_model(int x, int y);
      int s;
      s = x + y;
      return DW'(s / 2);
   endfunction

   task automatic chk(bit ok, string tag, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic send(logic [DW-1:0] x);
      @(negedge clk);
      in_data = x;
      in_req  = 1'b1;
      exp_q[n_sent] = avg_model(int'(x), y_model);
      y_model = int'(x);
      n_sent++;
      while (!in_ack) @(negedge clk);
      // R4: data may change once acknowledged
      in_data = ~x;
      repeat ($urandom % 4) begin
         @(negedge clk);
         chk(in_ack == 1'b1, "R5 ack held while req high", int'(in_ack), 1);
      end
      in_req = 1'b0;
      @(negedge clk);
      while (in_ack) @(negedge clk);
      in_data = $urandom;
      repeat ($urandom % 3) @(negedge clk);
   endtask

   // consumer with random acknowledge delay
   initial begin
      logic [DW-1:0] held;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (out_req) begin
            chk(out_data == exp_q[n_recv], "R2/R3 result value", int'(out_data), int'(exp_q[n_recv]));
            held = out_data;
            repeat ($urandom % 5) begin
               @(negedge clk);
               chk(out_req && out_data == held, "R6 output held until ack", int'(out_data), int'(held));
            end
            out_ack = 1'b1;
            n_recv++;
            @(negedge clk);
            while (out_req) @(negedge clk);
            repeat ($urandom % 3) begin
               @(negedge clk);
               chk(!out_req, "R6 no request while ack high", int'(out_req), 0);
            end
            out_ack = 1'b0;
         end
      end
   end

   // latency and exclusivity monitor
   initial begin
      logic pa, pr;
      int gap;
      pa = 0; pr = 0; gap = 0;
      @(posedge rst_n);
      forever begin
         @(negedge clk);
         if (pa && !in_ack) gap = 0;
         else gap++;
         if (out_req && !pr)
            chk(gap == EXP_GAP, "R8 in_ack fall to out_req rise", gap, EXP_GAP);
         if (in_ack && out_req)
            chk(0, "R7 in_ack with out_req", 1, 0);
         pa = in_ack;
         pr = out_req;
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!done_flag) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(in_ack == 1'b0, "R1 in_ack low after reset", int'(in_ack), 0);
      chk(out_req == 1'b0, "R1 out_req low after reset", int'(out_req), 0);
      // R1: first result is x/2 (y starts at 0); odd value checks truncation (R2)
      send(8'd201);
      send(8'd255);
      send(8'd255);   // R2 full-scale pair, no overflow
      send(8'd0);
      send(8'd1);     // R2 (0+1)/2 = 0
      send(8'd254);
      for (int i = 0; i < NRAND; i++) begin
         case ($urandom % 8)
            0:       send(8'd255);
            1:       send(8'd0);
            default: send(DW'($urandom));
         endcase
      end
      while (n_recv < n_sent) @(negedge clk);
      repeat (10) @(negedge clk);
      chk(n_recv == n_sent, "R3 all results delivered in order", n_recv, n_sent);
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule